// File: doc/BRIEF.md
# GPIO Interrupt Bank

This block is a memory-mapped controller for one bank of general-purpose pins. Software drives pins through an output value register and a per-pin drive-enable register. It reads the pin levels after a two-flop synchronizer. Each pin can also raise an interrupt.

The trigger for each pin is chosen by three independent configuration bits:
- Level versus edge sensing.
- A both-edges override for edge-sensed pins.
- An active polarity, which selects rising/high or falling/low.

Detected events latch into a raw status register. A per-pin enable register gates the raw status into a masked view. The OR of the masked view drives a single registered interrupt line. Software acknowledges a pin by writing a one to its bit in the acknowledge register, and it does this before servicing the pin.

Bus accesses use a plain address / write-enable / write-data / read-data port. A write takes effect at the clock edge where it is presented. Read data is registered and appears one cycle after the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, `pin_out`, `pin_oe` and `irq_out` are 0, all pins are inputs, and all interrupts are disabled.
- R2: Register map (byte offsets):
  - 0x00: synchronized pin levels (read-only).
  - 0x04: output value.
  - 0x08: drive enable.
  - 0x0C: interrupt enable.
  - 0x10: sense select (1 = level, 0 = edge).
  - 0x14: both-edges select.
  - 0x18: polarity (1 = rising/high, 0 = falling/low).
  - 0x1C: raw status.
  - 0x20: masked status (read-only).
  - 0x24: acknowledge (write-only, reads 0).

  Bit n of every register belongs to pin n. A write to 0x04 or 0x08 appears on `pin_out` / `pin_oe` in the next cycle and reads back unchanged.
- R3: Reads are registered: `bus_rdata` holds the value selected by the address one cycle after the address is presented. The pin level at 0x00 trails `pin_in` by two synchronizer stages.
- R4: An edge-sensed pin with polarity 1 sets its raw status bit on a 0-to-1 change of the synchronized input, and with polarity 0 on a 1-to-0 change. It does not set the bit on the opposite change. The bit is set on the third rising clock edge after `pin_in` changes.
- R5: An edge-sensed pin with the both-edges bit set triggers on either change, whatever its polarity bit holds.
- R6: A level-sensed pin keeps its raw status bit set in every cycle its synchronized input equals its polarity. An acknowledge has no effect during that time. The bit stays latched after the level goes inactive, until it is acknowledged.
- R7: Raw status latches whether or not the pin is enabled. The masked status at 0x20 is the raw status ANDed with the interrupt enable.
- R8: Writing 1 to an acknowledge bit clears that pin's raw status bit, and writing 0 leaves it unchanged. Writes to 0x1C, 0x20 and 0x00 change no state.
- R9: When an event and an acknowledge for the same pin fall in the same cycle, the status bit stays set.
- R10: `irq_out` is the OR of all masked status bits, registered one cycle after that OR changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Registered read data |
| pin_in | input | NPINS (32) | Asynchronous pin levels |
| pin_out | output | NPINS (32) | Output value for each pin |
| pin_oe | output | NPINS (32) | Drive enable for each pin (1 = output) |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The bench places an acknowledge write exactly on the clock edge where a fresh rising edge is detected. A design that let the clear win would read back a zero there.

It acknowledges a level-sensed pin while the level is still active. A design that treated level pins like edge pins would drop the bit.

It arms a both-edges pin whose polarity bit is 0 and expects a rising change to count. A design that still honoured polarity would miss it.

It samples the status one cycle before and on the cycle the third clock edge lands. It also reads the pin level twice before it settles. This exposes a missing or extra synchronizer stage, and an interrupt line that was left combinational.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [5:0] OFS_PIN_LVL   = 6'h00;
  localparam logic [5:0] OFS_DOUT      = 6'h04;
  localparam logic [5:0] OFS_DRV_EN    = 6'h08;
  localparam logic [5:0] OFS_IRQ_EN    = 6'h0C;
  localparam logic [5:0] OFS_SENSE_LVL = 6'h10;
  localparam logic [5:0] OFS_BOTH_EDGE = 6'h14;
  localparam logic [5:0] OFS_POL_HI    = 6'h18;
  localparam logic [5:0] OFS_RAW_ST    = 6'h1C;
  localparam logic [5:0] OFS_MSK_ST    = 6'h20;
  localparam logic [5:0] OFS_ACK       = 6'h24;

  typedef struct packed {
    logic lvl;   // 1: level sensing, 0: edge sensing
    logic both;  // edge on either transition
    logic hi;    // rising / high when set
  } trig_cfg_t;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_async;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_sync = stg_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      // R3
      sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q_sync == $past(d_async, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gpio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cur,
  input  trig_cfg_t cfg,
  input  logic      ack,
  output logic      st
);
  logic prv_q;
  logic st_q;
  logic rise, fall, evt_edge, evt_lvl, evt;

  always_comb begin
    rise     = cur & ~prv_q;
    fall     = ~cur & prv_q;
    evt_edge = cfg.both ? (rise | fall) : (cfg.hi ? rise : fall);
    evt_lvl  = (cur == cfg.hi);
    evt      = cfg.lvl ? evt_lvl : evt_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prv_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      prv_q <= cur;
      st_q  <= evt | (st_q & ~ack);
    end
  end

  assign st = st_q;

  // R6
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.lvl && (cur == cfg.hi)) |=> st);
  // R4
  st_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st) |-> $past(evt));
  // R9
  clr_race_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && ack) |=> st);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(OFS_PIN_LVL);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFS_DOUT);
  localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(OFS_DRV_EN);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_IRQ_EN);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(OFS_SENSE_LVL);
  localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(OFS_BOTH_EDGE);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL_HI);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW_ST);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFS_MSK_ST);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);

  logic [NPINS-1:0] dout_q, oe_q, en_q, lvl_q, both_q, hi_q;
  logic [NPINS-1:0] pin_s, raw_st, msk_st, ack_vec;
  logic [NPINS-1:0] rdata_q;
  logic             irq_q;

  gpio_sync2 #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_in),
    .q_sync  (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      oe_q   <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
      both_q <= '0;
      hi_q   <= '0;
    end else if (bus_we) begin
      unique case (bus_addr)
        A_DOUT:  dout_q <= bus_wdata;
        A_OE:    oe_q   <= bus_wdata;
        A_EN:    en_q   <= bus_wdata;
        A_LVL:   lvl_q  <= bus_wdata;
        A_BOTH:  both_q <= bus_wdata;
        A_POL:   hi_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign ack_vec = (bus_we && (bus_addr == A_ACK)) ? bus_wdata : '0;

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      trig_cfg_t cfg_i;
      assign cfg_i = '{lvl: lvl_q[i], both: both_q[i], hi: hi_q[i]};
      gpio_trig_det u_det (
        .clk (clk),
        .rst (rst),
        .cur (pin_s[i]),
        .cfg (cfg_i),
        .ack (ack_vec[i]),
        .st  (raw_st[i])
      );
    end
  endgenerate

  assign msk_st = raw_st & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= |msk_st;
      unique case (bus_addr)
        A_PIN:   rdata_q <= pin_s;
        A_DOUT:  rdata_q <= dout_q;
        A_OE:    rdata_q <= oe_q;
        A_EN:    rdata_q <= en_q;
        A_LVL:   rdata_q <= lvl_q;
        A_BOTH:  rdata_q <= both_q;
        A_POL:   rdata_q <= hi_q;
        A_RAW:   rdata_q <= raw_st;
        A_MSK:   rdata_q <= msk_st;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = dout_q;
  assign pin_oe    = oe_q;
  assign irq_out   = irq_q;

  // R2
  oe_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_OE) |=> (pin_oe == $past(bus_wdata)));
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|raw_st));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) == '0) |-> !irq_out);
endmodule

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [5:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_req = 1'b0;
  logic         rd_stage = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_irq_bank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  localparam logic [5:0] R_PIN = 6'h00, R_DOUT = 6'h04, R_OE = 6'h08,
    R_EN = 6'h0C, R_LVL = 6'h10, R_BOTH = 6'h14, R_POL = 6'h18,
    R_RAW = 6'h1C, R_MSK = 6'h20, R_ACK = 6'h24;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver tasks: called at a negedge, return at the next negedge
  task automatic bus_wr(input logic [5:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, input logic [N-1:0] exp, input string tag);
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares registered read data against the scoreboard
  always @(posedge clk) rd_stage <= rd_req;
  always @(negedge clk) begin
    if (rd_stage) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: read data with no expected item");
      end else begin
        automatic logic [N-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq_out", {31'b0, irq_out}, '0);
    bus_rd(R_DOUT, '0, "R1 dout");
    bus_rd(R_OE, '0, "R1 oe");
    bus_rd(R_EN, '0, "R1 enable");
    bus_rd(R_POL, '0, "R1 polarity");
    bus_rd(R_RAW, '0, "R1 raw");
    bus_rd(R_MSK, '0, "R1 masked");

    // R2 output registers
    bus_wr(R_DOUT, 32'hA5A5_0F0F);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    bus_wr(R_OE, 32'hFFFF_0000);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    bus_rd(R_DOUT, 32'hA5A5_0F0F, "R2 dout readback");
    bus_rd(R_OE, 32'hFFFF_0000, "R2 oe readback");
    bus_rd(R_ACK, '0, "R2 ack reads zero");

    // R3 two-stage sync latency
    pin_in = 32'h5A3C_0000;
    bus_rd(R_PIN, '0, "R3 pin level before sync 1");
    bus_rd(R_PIN, '0, "R3 pin level before sync 2");
    bus_rd(R_PIN, 32'h5A3C_0000, "R3 pin level synced");
    bus_wr(R_PIN, 32'hFFFF_FFFF);
    bus_rd(R_PIN, 32'h5A3C_0000, "R8 pin level write ignored");

    // R4 falling edge on pin 3 (default config), exact latency
    pin_in[3] = 1'b1;
    idle(4);
    bus_rd(R_RAW, '0, "R4 rising ignored in falling mode");
    pin_in[3] = 1'b0;
    idle(2);
    bus_rd(R_RAW, '0, "R4 status not yet set");
    bus_rd(R_RAW, 32'h0000_0008, "R4 falling edge latched");

    // R4 rising on pin 5
    bus_wr(R_POL, 32'h0000_0020);
    pin_in[5] = 1'b1;
    idle(4);
    bus_rd(R_RAW, 32'h0000_0028, "R4 rising edge latched");
    // R7 raw latched while disabled
    bus_rd(R_MSK, '0, "R7 masked zero when disabled");
    chk("R7 irq low when disabled", {31'b0, irq_out}, '0);

    // R8 write-one-to-clear
    bus_wr(R_ACK, 32'h0000_0008);
    bus_rd(R_RAW, 32'h0000_0020, "R8 ack clears only bit 3");
    bus_wr(R_ACK, 32'h0000_0000);
    bus_wr(R_RAW, 32'hFFFF_FFFF);
    bus_wr(R_MSK, 32'hFFFF_FFFF);
    bus_rd(R_RAW, 32'h0000_0020, "R8 zero ack and raw write ignored");

    // R9 event and acknowledge in the same cycle
    pin_in[5] = 1'b0;
    idle(4);
    bus_rd(R_RAW, 32'h0000_0020, "R9 prior status held");
    pin_in[5] = 1'b1;          // event lands on third edge from here
    idle(2);
    bus_wr(R_ACK, 32'h0000_0020);
    bus_rd(R_RAW, 32'h0000_0020, "R9 new event beats ack");
    bus_wr(R_ACK, 32'h0000_0020);
    bus_rd(R_RAW, '0, "R8 ack alone clears");

    // R5 both edges on pin 12, polarity 0
    bus_wr(R_BOTH, 32'h0000_1000);
    pin_in[12] = 1'b1;
    idle(4);
    bus_rd(R_RAW, 32'h0000_1000, "R5 rising counted despite polarity 0");
    bus_wr(R_ACK, 32'h0000_1000);
    pin_in[12] = 1'b0;
    idle(4);
    bus_rd(R_RAW, 32'h0000_1000, "R5 falling counted");
    bus_wr(R_ACK, 32'h0000_1000);
    bus_rd(R_RAW, '0, "R5 cleared");

    // R6 level high on pin 8
    bus_wr(R_POL, 32'h0000_0120);
    bus_wr(R_LVL, 32'h0000_0100);
    idle(3);
    bus_rd(R_RAW, '0, "R6 inactive level no status");
    pin_in[8] = 1'b1;
    idle(4);
    bus_rd(R_RAW, 32'h0000_0100, "R6 active high level");
    bus_wr(R_ACK, 32'h0000_0100);
    bus_rd(R_RAW, 32'h0000_0100, "R6 ack ignored while active");
    pin_in[8] = 1'b0;
    idle(4);
    bus_rd(R_RAW, 32'h0000_0100, "R6 stays latched after level drops");
    bus_wr(R_ACK, 32'h0000_0100);
    bus_rd(R_RAW, '0, "R6 ack after inactive");
    bus_wr(R_POL, 32'h0000_0020);  // active low now, pin 8 is low
    idle(1);
    bus_rd(R_RAW, 32'h0000_0100, "R6 active low level");
    bus_wr(R_POL, 32'h0000_0120);
    bus_wr(R_ACK, 32'h0000_0100);
    bus_rd(R_RAW, '0, "R6 cleared after polarity restore");

    // R7 / R10 enable, masked view and interrupt line
    pin_in[3] = 1'b1;
    idle(4);
    pin_in[3] = 1'b0;
    idle(4);
    chk("R10 irq low while disabled", {31'b0, irq_out}, '0);
    bus_wr(R_EN, 32'h0000_1008);
    chk("R10 irq registered one cycle", {31'b0, irq_out}, '0);
    idle(1);
    chk("R10 irq high", {31'b0, irq_out}, 32'h1);
    bus_rd(R_MSK, 32'h0000_0008, "R7 masked status");
    bus_rd(R_RAW, 32'h0000_0008, "R7 raw status");
    pin_in[12] = 1'b1;
    idle(4);
    bus_rd(R_MSK, 32'h0000_1008, "R7 masked two pins");
    bus_wr(R_ACK, 32'h0000_0008);
    idle(1);
    chk("R10 irq held by remaining pin", {31'b0, irq_out}, 32'h1);
    bus_wr(R_ACK, 32'h0000_1000);
    idle(1);
    chk("R10 irq low after all acked", {31'b0, irq_out}, '0);
    bus_rd(R_MSK, '0, "R7 masked cleared");

    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule